// File: doc/BRIEF.md
# Single-cycle 32-bit RISC core

This block is a small 32-bit load/store processor that completes one instruction on every rising clock edge. A word-indexed instruction store is fetched at the program counter. A three-way field split of each instruction drives a 32-entry register file, a sign extender and an arithmetic unit. A word-indexed data store serves loads and stores. The next program counter is chosen among the sequential address, a PC-relative branch target and a region-absolute jump target.

The instruction store is filled through a write port, normally while reset is held. After reset is released the core runs from address 0. Two combinational peek ports expose any register and any data word, so the results of a program can be read at the block's edge without reaching inside the design.

Top module: `core_top`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0, every register reads 0 and every data word reads 0. The first instruction executed after release is at word 0.
- R2: Field positions are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6] and funct [5:0]. Opcode 0x00 with shamt 0 and funct 0x20 (add), 0x22 (sub), 0x24 (and), 0x25 (or) or 0x2a (signed set-less-than) writes rs op rt into rd.
- R3: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate into rt.
- R4: Register 0 always reads 0, and a write aimed at it is discarded.
- R5: Opcode 0x2b (store) writes rt to the data word at rs plus the sign-extended offset. Opcode 0x23 (load) writes that word into rt. Byte address bits [1:0] are ignored.
- R6: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch sets the PC to PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the PC becomes PC+4.
- R7: Opcode 0x02 sets the PC to bits 31:28 of PC+4, then instruction bits 25:0, then two zero bits.
- R8: Every other instruction advances the PC by 4. Any other opcode, and any opcode-0 word with another funct or a non-zero shamt, changes no register and no data word.
- R9: A word written through the instruction load port at a word index is the instruction fetched when the PC equals four times that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Instruction store write enable |
| imem_sel_i | input | 6 | Instruction store word index |
| imem_wdata_i | input | 32 | Instruction word to store |
| dbg_reg_sel_i | input | 5 | Register peek index |
| dbg_reg_o | output | 32 | Register peek data |
| dbg_mem_sel_i | input | 6 | Data store peek word index |
| dbg_mem_o | output | 32 | Data store peek data |
| pc_o | output | 32 | Current program counter |

## Verification
The hardest case to reach from the ports is a backward conditional branch that is taken several times and then falls through. It exercises the negative offset, the not-taken path and a register that is both read and rewritten in the same cycle. A countdown loop closed by a not-equal branch with a word offset of -3 produces this, and the loop is followed by a taken and a not-taken equal branch and a forward jump over dead code. A behavioural instruction-level model in the bench tracks the program counter and one rotating register on every cycle. At the end it compares the full register and data contents, so a wrong target, a lost write or a stray write to register 0 appears at once.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2b;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2a;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    mem_we;
    logic    wb_mem;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [4:0] shamt_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (op_i)
      OP_RTYPE: begin
        if (shamt_i == 5'd0) begin
          ctrl_o.dst_rd = 1'b1;
          ctrl_o.reg_we = 1'b1;
          case (funct_i)
            FN_ADD:  ctrl_o.alu_op = ALU_ADD;
            FN_SUB:  ctrl_o.alu_op = ALU_SUB;
            FN_AND:  ctrl_o.alu_op = ALU_AND;
            FN_OR:   ctrl_o.alu_op = ALU_OR;
            FN_SLT:  ctrl_o.alu_op = ALU_SLT;
            default: ctrl_o.reg_we = 1'b0;
          endcase
        end
      end
      OP_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
      end
      OP_LW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.br_eq  = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_BNE: begin
        ctrl_o.br_ne  = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_J:    ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_sel_i,
  input  logic [AW-1:0] rb_sel_i,
  input  logic [AW-1:0] rc_sel_i,
  output logic [W-1:0]  ra_o,
  output logic [W-1:0]  rb_o,
  output logic [W-1:0]  rc_o,
  input  logic          we_i,
  input  logic [AW-1:0] wsel_i,
  input  logic [W-1:0]  wdata_i
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wsel_i != '0) begin
      regs_q[wsel_i] <= wdata_i;
    end
  end

  assign ra_o = (ra_sel_i == '0) ? '0 : regs_q[ra_sel_i];
  assign rb_o = (rb_sel_i == '0) ? '0 : regs_q[rb_sel_i];
  assign rc_o = (rc_sel_i == '0) ? '0 : regs_q[rc_sel_i];
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int XLEN = 32,
  localparam int NREG = 32,
  localparam int RA   = $clog2(NREG),
  localparam int IA   = $clog2(IMEM_WORDS),
  localparam int DA   = $clog2(DMEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            imem_we_i,
  input  logic [IA-1:0]   imem_sel_i,
  input  logic [XLEN-1:0] imem_wdata_i,
  input  logic [RA-1:0]   dbg_reg_sel_i,
  output logic [XLEN-1:0] dbg_reg_o,
  input  logic [DA-1:0]   dbg_mem_sel_i,
  output logic [XLEN-1:0] dbg_mem_o,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];
  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, imm_ext, rs_data, rt_data, alu_b, alu_y, ld_data, wb_data;
  logic [RA-1:0]   wsel;
  logic            alu_zero, br_take;
  ctrl_t           ctrl;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_sel_i] <= imem_wdata_i;
  end

  assign instr   = imem[pc_q[IA+1:2]];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  core_decode u_dec (
    .op_i    (instr[31:26]),
    .shamt_i (instr[10:6]),
    .funct_i (instr[5:0]),
    .ctrl_o  (ctrl)
  );

  assign wsel = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  core_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_sel_i (instr[25:21]),
    .rb_sel_i (instr[20:16]),
    .rc_sel_i (dbg_reg_sel_i),
    .ra_o     (rs_data),
    .rb_o     (rt_data),
    .rc_o     (dbg_reg_o),
    .we_i     (ctrl.reg_we),
    .wsel_i   (wsel),
    .wdata_i  (wb_data)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rt_data;

  core_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // word-indexed data store; byte offset bits dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem_q[i] <= '0;
    end else if (ctrl.mem_we) begin
      dmem_q[alu_y[DA+1:2]] <= rt_data;
    end
  end

  assign ld_data   = dmem_q[alu_y[DA+1:2]];
  assign wb_data   = ctrl.wb_mem ? ld_data : alu_y;
  assign dbg_mem_o = dmem_q[dbg_mem_sel_i];

  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign br_take  = (ctrl.br_eq & alu_zero) | (ctrl.br_ne & ~alu_zero);

  always_comb begin
    if (ctrl.jump)   pc_next = jmp_tgt;
    else if (br_take) pc_next = br_tgt;
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/core_top_chk.sv
module core_top_chk
  import core_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic [31:0] rs_data_i,
  input logic [31:0] rt_data_i
);
  logic [5:0] op;
  assign op = instr_i[31:26];

  p_pc_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[1:0] == 2'b00);

  p_seq_pc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_J && op != OP_BEQ && op != OP_BNE) |=> pc_i == $past(pc_i) + 32'd4);

  p_jump_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_J) |=> pc_i == {$past(pc_i[31:28] + {3'b000, &pc_i[27:2]}),
                              $past(instr_i[25:0]), 2'b00});

  p_branch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op == OP_BEQ && rs_data_i == rt_data_i) || (op == OP_BNE && rs_data_i != rt_data_i))
    |=> pc_i == $past(pc_i) + 32'd4 + {{14{$past(instr_i[15])}}, $past(instr_i[15:0]), 2'b00});

  p_nobranch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op == OP_BEQ && rs_data_i != rt_data_i) || (op == OP_BNE && rs_data_i == rt_data_i))
    |=> pc_i == $past(pc_i) + 32'd4);

  p_zero_rs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[25:21] == 5'd0) |-> rs_data_i == 32'd0);

  p_zero_rt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[20:16] == 5'd0) |-> rt_data_i == 32'd0);
endmodule

bind core_top core_top_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_i      (pc_q),
  .instr_i   (instr),
  .rs_data_i (rs_data),
  .rt_data_i (rt_data)
);

// File: tb/tb_core_top.sv
module tb_core_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 70;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we_i = 1'b0;
  logic [5:0]  imem_sel_i = '0;
  logic [31:0] imem_wdata_i = '0;
  logic [4:0]  dbg_reg_sel_i = '0;
  logic [31:0] dbg_reg_o;
  logic [5:0]  dbg_mem_sel_i = '0;
  logic [31:0] dbg_mem_o;
  logic [31:0] pc_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] prog [64];
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  core_top dut (.*);

  function automatic logic [31:0] rtype(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] jtype(input int idx);
    return {6'h02, idx[25:0]};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural instruction-level model, one instruction per call
  task automatic model_step();
    logic [31:0] ins, a, b, sx, nxt, ea;
    logic [5:0] op, fn;
    int rs, rt, rd;
    ins = prog[mpc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = mreg[rs]; b = mreg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    nxt = mpc + 32'd4;
    ea = a + sx;
    case (op)
      6'h00: if (ins[10:6] == 5'd0) begin
        case (fn)
          6'h20: if (rd != 0) mreg[rd] = a + b;
          6'h22: if (rd != 0) mreg[rd] = a - b;
          6'h24: if (rd != 0) mreg[rd] = a & b;
          6'h25: if (rd != 0) mreg[rd] = a | b;
          6'h2a: if (rd != 0) mreg[rd] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: ;
        endcase
      end
      6'h08: if (rt != 0) mreg[rt] = ea;
      6'h23: if (rt != 0) mreg[rt] = mmem[ea[7:2]];
      6'h2b: mmem[ea[7:2]] = b;
      6'h04: if (a == b) nxt = mpc + 32'd4 + (sx << 2);
      6'h05: if (a != b) nxt = mpc + 32'd4 + (sx << 2);
      6'h02: nxt = {nxt[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    mpc = nxt;
  endtask

  function automatic string pc_tag(input logic [31:0] ins);
    case (ins[31:26])
      6'h02: return "R7";
      6'h04, 6'h05: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic string reg_tag(input int r);
    case (r)
      0: return "R4";
      1, 2, 8, 12: return "R3";
      11: return "R5";
      13: return "R6";
      14: return "R7";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 2000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = itype(6'h08, 0, 8, 40);
    prog[1]  = itype(6'h08, 0, 1, 7);
    prog[2]  = itype(6'h08, 0, 2, -3);
    prog[3]  = rtype(6'h20, 1, 2, 3);
    prog[4]  = rtype(6'h22, 2, 1, 4);
    prog[5]  = rtype(6'h24, 1, 2, 5);
    prog[6]  = rtype(6'h25, 1, 2, 6);
    prog[7]  = rtype(6'h2a, 2, 1, 7);
    prog[8]  = rtype(6'h2a, 1, 2, 9);
    prog[9]  = itype(6'h08, 0, 0, 5);        // R4 write to r0 dropped
    prog[10] = rtype(6'h20, 0, 1, 10);
    prog[11] = itype(6'h2b, 8, 4, 8);
    prog[12] = itype(6'h2b, 8, 1, -4);
    prog[13] = itype(6'h23, 8, 11, 8);
    prog[14] = itype(6'h08, 0, 12, 3);
    prog[15] = itype(6'h08, 13, 13, 2);
    prog[16] = itype(6'h08, 12, 12, -1);
    prog[17] = itype(6'h05, 12, 0, -3);      // R6 backward loop
    prog[18] = itype(6'h04, 1, 1, 1);
    prog[19] = itype(6'h08, 0, 14, 99);
    prog[20] = itype(6'h04, 1, 2, 1);
    prog[21] = jtype(24);
    prog[22] = itype(6'h08, 0, 14, 55);
    prog[23] = itype(6'h08, 0, 14, 66);
    prog[24] = itype(6'h2b, 0, 13, 0);
    prog[25] = 32'hfc21_0000;                // R8 unknown opcode
    prog[26] = {6'h00, 5'd1, 5'd2, 5'd15, 5'd3, 6'h20}; // R8 shamt set
    prog[27] = rtype(6'h3f, 1, 2, 16);       // R8 unknown funct
    prog[28] = itype(6'h08, 0, 14, 11);
    prog[29] = jtype(29);

    // R9 fill instruction store while reset holds
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_i);
      imem_we_i = 1'b1; imem_sel_i = i[5:0]; imem_wdata_i = prog[i];
    end
    @(negedge clk_i);
    imem_we_i = 1'b0;

    dbg_reg_sel_i = 5'd9; dbg_mem_sel_i = 6'd12;
    #1;
    check("R1", "pc in reset", pc_o, 32'h0);
    check("R1", "reg in reset", dbg_reg_o, 32'h0);
    check("R1", "mem in reset", dbg_mem_o, 32'h0);

    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int i = 0; i < 64; i++) mmem[i] = '0;
    mpc = '0;

    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      dbg_reg_sel_i = c[4:0];
      #1;
      check(pc_tag(prog[mpc[7:2]]), "pc", pc_o, mpc);
      check(reg_tag(c % 32), "reg peek", dbg_reg_o, mreg[c % 32]);
      model_step();
      @(negedge clk_i);
    end

    for (int r = 0; r < 32; r++) begin
      dbg_reg_sel_i = r[4:0];
      #1;
      check(reg_tag(r), "final reg", dbg_reg_o, mreg[r]);
    end
    for (int m = 0; m < 64; m++) begin
      dbg_mem_sel_i = m[5:0];
      #1;
      check("R5", "final mem", dbg_mem_o, mmem[m]);
    end
    // spot values from the requirements
    dbg_reg_sel_i = 5'd13; #1; check("R6", "loop sum", dbg_reg_o, 32'd6);
    dbg_reg_sel_i = 5'd14; #1; check("R7", "skip marker", dbg_reg_o, 32'd11);
    dbg_reg_sel_i = 5'd7;  #1; check("R2", "slt signed", dbg_reg_o, 32'd1);
    dbg_reg_sel_i = 5'd15; #1; check("R8", "shamt nop", dbg_reg_o, 32'd0);
    dbg_mem_sel_i = 6'd12; #1; check("R5", "store word", dbg_mem_o, 32'hffff_fff6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule